// File: doc/BRIEF.md
# Network Interface Interrupt Moderator

This block gathers the interrupt causes of a network interface and decides when the single interrupt line to the host goes high. Causes arrive as hardware pulses, as writes to a cause-set register, or from receive and transmit delay timers. The block holds a cause register, an enable mask and a throttle interval. A cause enters the cause register at once. The throttle interval then decides whether the line rises in the next cycle or only when the interval ends.

Each direction has two delay timers. The packet timer restarts on every qualifying event, so it fires only after traffic goes quiet. The absolute timer starts on the first event and is not restarted, which bounds how long traffic can hold the interrupt back. Every timer counts `tick_i` pulses, and `tick_i` is a one-cycle strobe from a slower interrupt time base. Software reads the cause register through a read strobe. A read clears the register and lowers the line.

Top module: `nic_irq_moderator`

## Requirements
- R1: With the throttle interval at zero, a `cause_set_i` pulse that has at least one bit enabled in the mask raises `irq_o` at the next clock edge.
- R2: With a nonzero throttle interval N (register select 2), a hardware-posted cause starts the throttle count if it is idle. `irq_o` rises one edge after the N-th following tick, provided an enabled cause is still pending.
- R3: A cause whose mask bit (register select 0, bit set = enabled) is clear never drives `irq_o` high.
- R4: A write to the mask re-evaluates the pending causes. If the throttle interval is zero and an enabled cause is pending, `irq_o` rises at the next edge.
- R5: A completed received packet with a nonzero receive packet delay (select 3) reloads the receive packet timer and drops any earlier count. When that timer expires, cause bit 0 is set.
- R6: A completed received packet with a nonzero receive absolute delay (select 4) starts the absolute timer only if it is idle. Its expiry also sets cause bit 0.
- R7: If both receive delays are zero, a completed received packet sets cause bit 0 at the next edge.
- R8: A received packet whose length is at or below the small-packet threshold (select 5) sets cause bit 2.
- R9: A transmit done with the delay request set behaves as follows. A nonzero transmit packet delay (select 6) reloads the transmit packet timer. The transmit absolute timer (select 7) starts only when both transmit delays are nonzero and that timer is idle. If the packet delay is zero, cause bit 1 is set at once. Either timer's expiry sets cause bit 1. A transmit done without the request has no effect.
- R10: A write to the cause-set register (select 1) posts the written bits and bypasses the throttle. Enabled bits raise `irq_o` at the next edge.
- R11: A read strobe shows the cause register on `rd_data_o` in that cycle. At the edge it clears the register and lowers `irq_o`. Causes posted in the same cycle are kept.
- R12: After reset the cause register, the mask, all interval values and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Interrupt time-base strobe |
| cause_set_i | input | CAUSE_W | Hardware cause pulses |
| rx_done_i | input | 1 | Received packet completed |
| rx_len_i | input | LEN_W | Length of the completed packet |
| tx_done_i | input | 1 | Transmit descriptor done |
| tx_dly_req_i | input | 1 | Descriptor requests a delayed interrupt |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select |
| wr_data_i | input | DLY_W | Write data |
| rd_i | input | 1 | Read-and-clear strobe for the cause register |
| rd_data_o | output | CAUSE_W | Cause register contents |
| irq_o | output | 1 | Interrupt line |

## Verification
Two kinds of collision are the main concern. The first is a read-and-clear strobe in the same cycle as a new cause post. The second is a timer expiry or cause post in the same cycle as the throttle interval ending. The bench forces the read collision directly by raising `rd_i` and `cause_set_i` together. It then reaches both collisions many more times with a long pseudo-random stretch of pulses, packets, reads and mask writes under a running throttle. A behavioural model compares `irq_o` and `rd_data_o` on every clock. The directed checks confirm that the old value is returned and the new cause survives.

// File: rtl/nic_irq_pkg.sv
`timescale 1ns/1ps
package nic_irq_pkg;
  typedef enum logic [2:0] {
    SEL_MASK      = 3'd0,
    SEL_CAUSE_SET = 3'd1,
    SEL_THROTTLE  = 3'd2,
    SEL_RX_PKT    = 3'd3,
    SEL_RX_ABS    = 3'd4,
    SEL_SMALL     = 3'd5,
    SEL_TX_PKT    = 3'd6,
    SEL_TX_ABS    = 3'd7
  } reg_sel_e;

  localparam int BIT_RX_TMR = 0;
  localparam int BIT_TX_TMR = 1;
  localparam int BIT_SMALL  = 2;

  localparam int NUM_TMR    = 5;
  localparam int TMR_RX_PKT = 0;
  localparam int TMR_RX_ABS = 1;
  localparam int TMR_TX_PKT = 2;
  localparam int TMR_TX_ABS = 3;
  localparam int TMR_THR    = 4;
endpackage

// File: rtl/irq_delay_timer.sv
`timescale 1ns/1ps
module irq_delay_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             expire_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (restart_i) begin
      cnt_d  = load_i;
      cnt_en = 1'b1;
    end else if (start_i && cnt_q == '0) begin
      cnt_d  = load_i;
      cnt_en = 1'b1;
    end else if (tick_i && cnt_q != '0) begin
      cnt_d  = cnt_q - ONE;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o   = (cnt_q != '0);
  assign expire_o = tick_i && (cnt_q == ONE) && !restart_i;

  // a restart always discards the running count
  assert_restart_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == $past(load_i)));

  // a start request on a running timer leaves its count alone
  assert_start_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !restart_i && cnt_q != '0) |=>
      (cnt_q == ($past(tick_i) ? $past(cnt_q) - ONE : $past(cnt_q))));
endmodule

// File: rtl/irq_cause_ctrl.sv
`timescale 1ns/1ps
module irq_cause_ctrl #(
  parameter int CAUSE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] hw_post_i,
  input  logic [CAUSE_W-1:0] imm_post_i,
  input  logic               mask_wr_i,
  input  logic [CAUSE_W-1:0] mask_data_i,
  input  logic               rd_i,
  input  logic               thr_zero_i,
  input  logic               thr_expire_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               irq_o
);
  logic [CAUSE_W-1:0] cause_q, cause_d, mask_q, mask_d;
  logic               irq_q, irq_d, pend_d, raise;

  always_comb begin
    mask_d  = mask_wr_i ? mask_data_i : mask_q;
    cause_d = (rd_i ? '0 : cause_q) | hw_post_i | imm_post_i;
    pend_d  = |(cause_d & mask_d);
    raise   = pend_d && ((thr_zero_i && ((|hw_post_i) || mask_wr_i)) ||
                         (|imm_post_i) || thr_expire_i);
    irq_d   = (irq_q && !rd_i) || raise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= cause_d;
      irq_q   <= irq_d;
      if (mask_wr_i) mask_q <= mask_d;
    end
  end

  assign cause_o = cause_q;
  assign irq_o   = irq_q && |(cause_q & mask_q);

  assert_unthrottled_post_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_zero_i && !mask_wr_i && |(hw_post_i & mask_q)) |=> irq_o);

  assert_mask_reeval_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr_i && thr_zero_i && !rd_i && |(cause_q & mask_data_i)) |=> irq_o);

  assert_imm_post_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|imm_post_i) |=> ((cause_o & $past(imm_post_i)) == $past(imm_post_i)));

  assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && hw_post_i == '0 && imm_post_i == '0) |=> (cause_o == '0 && !irq_o));
endmodule

// File: rtl/nic_irq_moderator.sv
`timescale 1ns/1ps
module nic_irq_moderator
  import nic_irq_pkg::*;
#(
  parameter int CAUSE_W = 8,
  parameter int DLY_W   = 16,
  parameter int LEN_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic [CAUSE_W-1:0] cause_set_i,
  input  logic               rx_done_i,
  input  logic [LEN_W-1:0]   rx_len_i,
  input  logic               tx_done_i,
  input  logic               tx_dly_req_i,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_sel_i,
  input  logic [DLY_W-1:0]   wr_data_i,
  input  logic               rd_i,
  output logic [CAUSE_W-1:0] rd_data_o,
  output logic               irq_o
);
  localparam logic [CAUSE_W-1:0] RX_BIT = CAUSE_W'(1) << BIT_RX_TMR;
  localparam logic [CAUSE_W-1:0] TX_BIT = CAUSE_W'(1) << BIT_TX_TMR;
  localparam logic [CAUSE_W-1:0] SM_BIT = CAUSE_W'(1) << BIT_SMALL;

  logic [DLY_W-1:0] thr_q, rx_pkt_q, rx_abs_q, tx_pkt_q, tx_abs_q;
  logic [LEN_W-1:0] small_q;
  reg_sel_e         sel;
  logic             tx_evt, mask_wr;
  logic [CAUSE_W-1:0] hw_post, imm_post;

  logic [NUM_TMR-1:0] tmr_restart, tmr_start, tmr_expire, tmr_busy;
  logic [DLY_W-1:0]   tmr_load [NUM_TMR];

  assign sel    = reg_sel_e'(wr_sel_i);
  assign tx_evt = tx_done_i && tx_dly_req_i;

  // interval registers, one clock enable each
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q    <= '0;
      rx_pkt_q <= '0;
      rx_abs_q <= '0;
      small_q  <= '0;
      tx_pkt_q <= '0;
      tx_abs_q <= '0;
    end else if (wr_en_i) begin
      if (sel == SEL_THROTTLE) thr_q    <= wr_data_i;
      if (sel == SEL_RX_PKT)   rx_pkt_q <= wr_data_i;
      if (sel == SEL_RX_ABS)   rx_abs_q <= wr_data_i;
      if (sel == SEL_SMALL)    small_q  <= LEN_W'(wr_data_i);
      if (sel == SEL_TX_PKT)   tx_pkt_q <= wr_data_i;
      if (sel == SEL_TX_ABS)   tx_abs_q <= wr_data_i;
    end
  end

  // timer requests
  always_comb begin
    tmr_restart = '0;
    tmr_start   = '0;
    tmr_restart[TMR_RX_PKT] = rx_done_i && (rx_pkt_q != '0);
    tmr_start[TMR_RX_ABS]   = rx_done_i && (rx_abs_q != '0);
    tmr_restart[TMR_TX_PKT] = tx_evt && (tx_pkt_q != '0);
    tmr_start[TMR_TX_ABS]   = tx_evt && (tx_pkt_q != '0) && (tx_abs_q != '0);
    tmr_start[TMR_THR]      = (|hw_post) && (thr_q != '0);
    tmr_load[TMR_RX_PKT]    = rx_pkt_q;
    tmr_load[TMR_RX_ABS]    = rx_abs_q;
    tmr_load[TMR_TX_PKT]    = tx_pkt_q;
    tmr_load[TMR_TX_ABS]    = tx_abs_q;
    tmr_load[TMR_THR]       = thr_q;
  end

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    irq_delay_timer #(.CNT_W(DLY_W)) tmr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .restart_i (tmr_restart[g]),
      .start_i   (tmr_start[g]),
      .load_i    (tmr_load[g]),
      .expire_o  (tmr_expire[g]),
      .busy_o    (tmr_busy[g])
    );
  end

  // cause posting
  always_comb begin
    hw_post = cause_set_i;
    if (rx_done_i && rx_pkt_q == '0 && rx_abs_q == '0) hw_post = hw_post | RX_BIT;
    if (rx_done_i && rx_len_i <= small_q)              hw_post = hw_post | SM_BIT;
    if (tx_evt && tx_pkt_q == '0)                      hw_post = hw_post | TX_BIT;
    if (tmr_expire[TMR_RX_PKT] || tmr_expire[TMR_RX_ABS]) hw_post = hw_post | RX_BIT;
    if (tmr_expire[TMR_TX_PKT] || tmr_expire[TMR_TX_ABS]) hw_post = hw_post | TX_BIT;
    imm_post = (wr_en_i && sel == SEL_CAUSE_SET) ? wr_data_i[CAUSE_W-1:0] : '0;
  end

  assign mask_wr = wr_en_i && (sel == SEL_MASK);

  irq_cause_ctrl #(.CAUSE_W(CAUSE_W)) cause_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_post_i    (hw_post),
    .imm_post_i   (imm_post),
    .mask_wr_i    (mask_wr),
    .mask_data_i  (wr_data_i[CAUSE_W-1:0]),
    .rd_i         (rd_i),
    .thr_zero_i   (thr_q == '0),
    .thr_expire_i (tmr_expire[TMR_THR]),
    .cause_o      (rd_data_o),
    .irq_o        (irq_o)
  );

  assert_rx_no_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_i && rx_pkt_q == '0 && rx_abs_q == '0) |=> rd_data_o[BIT_RX_TMR]);

  assert_small_packet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_i && rx_len_i <= small_q) |=> rd_data_o[BIT_SMALL]);

  assert_tx_no_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt && tx_pkt_q == '0) |=> rd_data_o[BIT_TX_TMR]);
endmodule

// File: tb/nic_irq_moderator_tb_top.sv
`timescale 1ns/1ps
module nic_irq_moderator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [7:0]  cause_set_i = '0;
  logic        rx_done_i = 1'b0;
  logic [15:0] rx_len_i = '0;
  logic        tx_done_i = 1'b0;
  logic        tx_dly_req_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        rd_i = 1'b0;
  logic [7:0]  rd_data_o;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  string phase = "R12";
  bit finished = 0;

  always #2 clk = ~clk;

  nic_irq_moderator dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cause_set_i(cause_set_i),
    .rx_done_i(rx_done_i), .rx_len_i(rx_len_i), .tx_done_i(tx_done_i),
    .tx_dly_req_i(tx_dly_req_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .rd_i(rd_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  // tick strobe every fourth cycle
  int tk = 0;
  always @(negedge clk) begin
    tk = (tk + 1) % 4;
    tick_i = (tk == 0);
  end

  // behavioural reference model
  int        m_cnt [5];
  int        m_reg [8];
  bit [7:0]  m_cause, m_mask;
  bit        m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      foreach (m_reg[i]) m_reg[i] = 0;
      m_cause = 0; m_mask = 0; m_irq = 0;
    end else begin
      bit rs [5];
      bit st [5];
      int ld [5];
      bit ex [5];
      bit [7:0] hw, imm, nc, nm;
      bit txe, raise;
      txe = tx_done_i && tx_dly_req_i;
      rs = '{default: 0};
      st = '{default: 0};
      ld[0] = m_reg[3]; ld[1] = m_reg[4]; ld[2] = m_reg[6]; ld[3] = m_reg[7]; ld[4] = m_reg[2];
      rs[0] = rx_done_i && m_reg[3] != 0;
      st[1] = rx_done_i && m_reg[4] != 0;
      rs[2] = txe && m_reg[6] != 0;
      st[3] = txe && m_reg[6] != 0 && m_reg[7] != 0;
      for (int i = 0; i < 5; i++) ex[i] = tick_i && m_cnt[i] == 1 && !rs[i];
      hw = cause_set_i;
      if (rx_done_i && m_reg[3] == 0 && m_reg[4] == 0) hw[0] = 1;
      if (rx_done_i && int'(rx_len_i) <= m_reg[5]) hw[2] = 1;
      if (txe && m_reg[6] == 0) hw[1] = 1;
      if (ex[0] || ex[1]) hw[0] = 1;
      if (ex[2] || ex[3]) hw[1] = 1;
      imm = (wr_en_i && wr_sel_i == 1) ? wr_data_i[7:0] : 8'h00;
      st[4] = (hw != 0) && m_reg[2] != 0;
      nm = (wr_en_i && wr_sel_i == 0) ? wr_data_i[7:0] : m_mask;
      nc = (rd_i ? 8'h00 : m_cause) | hw | imm;
      raise = ((nc & nm) != 0) &&
              ((m_reg[2] == 0 && (hw != 0 || (wr_en_i && wr_sel_i == 0))) ||
               imm != 0 || ex[4]);
      m_irq = (m_irq && !rd_i) || raise;
      for (int i = 0; i < 5; i++) begin
        if (rs[i]) m_cnt[i] = ld[i];
        else if (st[i] && m_cnt[i] == 0) m_cnt[i] = ld[i];
        else if (tick_i && m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 1;
      end
      m_cause = nc; m_mask = nm;
      if (wr_en_i && wr_sel_i >= 2) m_reg[wr_sel_i] = int'(wr_data_i);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_irq;
      e_irq = m_irq && ((m_cause & m_mask) != 0);
      checks++;
      if (irq_o !== e_irq || rd_data_o !== m_cause) begin
        errors++;
        $display("FAIL %s model: irq=%0b cause=%02h expected irq=%0b cause=%02h",
                 phase, irq_o, rd_data_o, e_irq, m_cause);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    wr_en_i = 1; wr_sel_i = s; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic hw(input logic [7:0] b);
    cause_set_i = b;
    @(negedge clk);
    cause_set_i = 0;
  endtask

  task automatic rxp(input int len);
    rx_done_i = 1; rx_len_i = 16'(len);
    @(negedge clk);
    rx_done_i = 0;
  endtask

  task automatic txp(input bit req);
    tx_done_i = 1; tx_dly_req_i = req;
    @(negedge clk);
    tx_done_i = 0; tx_dly_req_i = 0;
  endtask

  task automatic rd(output logic [7:0] v);
    rd_i = 1; v = rd_data_o;
    @(negedge clk);
    rd_i = 0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int seed;
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk(rd_data_o == 0 && irq_o == 0, "R12 reset", {rd_data_o, 7'b0, irq_o}, 0);

    phase = "R1";
    wr(0, 16'h00FF);
    hw(8'h08);
    chk(irq_o == 1, "R1 unthrottled post", irq_o, 1);
    phase = "R11";
    rd(v);
    chk(v == 8'h08, "R11 read value", v, 8'h08);
    chk(irq_o == 0 && rd_data_o == 0, "R11 read clears", {rd_data_o, 7'b0, irq_o}, 0);

    phase = "R3";
    wr(0, 16'h00F7);
    hw(8'h08);
    cyc(3);
    chk(irq_o == 0, "R3 masked cause", irq_o, 0);
    phase = "R4";
    wr(0, 16'h00FF);
    chk(irq_o == 1, "R4 mask write re-evaluates", irq_o, 1);
    rd(v);

    phase = "R2";
    wr(2, 16'd3);
    hw(8'h10);
    cyc(1);
    chk(irq_o == 0, "R2 throttle holds line", irq_o, 0);
    cyc(20);
    chk(irq_o == 1, "R2 throttle expiry raises", irq_o, 1);
    rd(v);
    phase = "R10";
    wr(1, 16'h0020);
    chk(irq_o == 1 && rd_data_o == 8'h20, "R10 cause-set write bypasses throttle",
        {rd_data_o, 7'b0, irq_o}, {8'h20, 8'h01});
    rd(v);
    wr(2, 16'd0);

    phase = "R7";
    rxp(100);
    chk(rd_data_o == 8'h01, "R7 no receive delay", rd_data_o, 8'h01);
    rd(v);

    phase = "R8";
    wr(5, 16'd64);
    rxp(64);
    chk(rd_data_o == 8'h05, "R8 length at threshold", rd_data_o, 8'h05);
    rd(v);
    rxp(65);
    chk(rd_data_o == 8'h01, "R8 length above threshold", rd_data_o, 8'h01);
    rd(v);

    phase = "R5";
    wr(3, 16'd3);
    rxp(200);
    cyc(2);
    chk(rd_data_o[0] == 0, "R5 timer still counting", rd_data_o[0], 0);
    cyc(20);
    chk(rd_data_o[0] == 1, "R5 packet timer expiry", rd_data_o[0], 1);
    rd(v);

    phase = "R6";
    wr(4, 16'd5);
    for (int i = 0; i < 8; i++) begin
      rxp(200);
      cyc(5);
    end
    chk(rd_data_o[0] == 1, "R6 absolute timer fires under traffic", rd_data_o[0], 1);
    cyc(30);
    rd(v);
    wr(3, 0);
    wr(4, 0);

    phase = "R9";
    wr(6, 16'd2);
    wr(7, 16'd4);
    txp(0);
    cyc(15);
    chk(rd_data_o == 0, "R9 no request ignored", rd_data_o, 0);
    txp(1);
    cyc(15);
    chk(rd_data_o[1] == 1, "R9 transmit timer expiry", rd_data_o[1], 1);
    rd(v);
    wr(6, 0);
    txp(1);
    chk(rd_data_o == 8'h02, "R9 zero packet delay posts at once", rd_data_o, 8'h02);
    rd(v);
    wr(7, 0);

    phase = "R11";
    hw(8'h08);
    rd_i = 1; cause_set_i = 8'h40; v = rd_data_o;
    @(negedge clk);
    rd_i = 0; cause_set_i = 0;
    chk(v == 8'h08, "R11 collision returns old", v, 8'h08);
    chk(rd_data_o == 8'h40 && irq_o == 1, "R11 collision keeps new cause",
        {rd_data_o, 7'b0, irq_o}, {8'h40, 8'h01});
    rd(v);

    phase = "R2 mix";
    wr(2, 16'd2);
    wr(3, 16'd2);
    wr(4, 16'd6);
    wr(6, 16'd3);
    wr(7, 16'd5);
    seed = 7;
    for (int i = 0; i < 600; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      cause_set_i  = ((seed >> 8) % 9 == 0) ? 8'((seed >> 12) & 8'hF8) : 8'h00;
      rx_done_i    = ((seed >> 4) % 7 == 0);
      rx_len_i     = 16'((seed >> 16) % 128);
      tx_done_i    = ((seed >> 6) % 6 == 0);
      tx_dly_req_i = seed[20];
      rd_i         = ((seed >> 10) % 11 == 0);
      wr_en_i      = ((seed >> 14) % 29 == 0);
      wr_sel_i     = 3'd0;
      wr_data_i    = 16'(seed >> 3);
      @(negedge clk);
    end
    cause_set_i = 0; rx_done_i = 0; tx_done_i = 0; tx_dly_req_i = 0; rd_i = 0; wr_en_i = 0;
    cyc(40);

    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule